// File: doc/BRIEF.md
# Keyed Configuration Port with Logical-Device Banking

This block is the configuration front end of a legacy I/O controller. The host reaches it through two byte-wide I/O addresses: an index port at the base address and a data port at base plus one. A strap input picks the base, 0x2E when low and 0x4E when high. Configuration space stays locked until the host writes the entry key 0x87 twice in a row to the index port. Once the port is open, the host writes a register number to the index port and then reads or writes that register through the data port. Writing the exit key 0xAA to the index port locks the port again.

Register numbers below 0x30 form the global space. Register 0x07 holds the logical-device number. Registers 0x20 and 0x21 return a 16-bit chip identifier. Every other global number is passed outward on a global strobe pair. Register numbers from 0x30 upward are banked: a data-port access raises the strobe of only the logical device that register 0x07 currently names. The device returns read data from the current index and device-select outputs within the same cycle.

The unlock logic is a three-state machine: LOCKED, ARMED and OPEN. The transitions are:
- LOCKED to ARMED: the entry key is written to the index port.
- ARMED to OPEN: the entry key is written to the index port again.
- ARMED to LOCKED: any other write to either port.
- OPEN to LOCKED: the exit key is written to the index port.

Any other index write in OPEN loads the index register. Reset enters LOCKED.

Top module: `cfg_port_frontend`

## Requirements
- R1: After reset the port is locked (`cfg_open` low), the index is 0x00, the logical device is 0x00, and no strobe or read-valid is active.
- R2: Two successive writes of 0x87 to the index port open the port, and `cfg_open` is high in the cycle after the second write.
- R3: Any write to the index or data port other than 0x87 that falls between the two key writes returns the machine to LOCKED. The sequence 0x87, other write, 0x87 therefore leaves the port locked.
- R4: Writing 0xAA to the index port while open locks the port. The index and logical-device values are kept, so after unlocking again an index-port read returns the earlier index.
- R5: While the port is not open, data-port writes cause no strobe and change no register, and reads of either port return 0xFF with `io_rdata_vld` high.
- R6: The index port is at 0x2E and the data port at 0x2F when `strap_hi` is low; they are at 0x4E and 0x4F when it is high. Accesses to any other address produce no read-valid and no state change.
- R7: Register 0x07 is read/write and drives `ldev_sel`. Writing it raises no outward strobe.
- R8: Registers 0x20 and 0x21 read the high and low bytes of the ID {0xA23, CHIP_REV}, which is 0xA232 by default. Writes to them are ignored and raise no strobe.
- R9: For index 0x30 and above, a data access raises bit `ldev_sel` of `dev_wr_stb` or `dev_rd_stb` and presents the index on `acc_index` and the write byte on `acc_wdata`. A read returns that device's slice of `dev_rdata`. If `ldev_sel` is NUM_DEV or more, no strobe is raised and a read returns 0xFF.
- R10: For any other index below 0x30 (not 0x07, 0x20 or 0x21), a data access raises `glb_wr_stb` or `glb_rd_stb`, and a read returns `glb_rdata`.
- R11: Strobes, `io_rdata` and `io_rdata_vld` are registered. They are valid in the cycle after the host access and last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_hi | input | 1 | Base select: 0 gives 0x2E, 1 gives 0x4E |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write, one cycle per access |
| io_rd | input | 1 | Host read, one cycle per access |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Registered read byte |
| io_rdata_vld | output | 1 | Read hit one of the two ports |
| cfg_open | output | 1 | Port is in configuration mode |
| cfg_index | output | 8 | Current index register |
| ldev_sel | output | 8 | Current logical-device number |
| dev_rdata | input | NUM_DEV*8 | Per-device read byte, device d at bits d*8 upward |
| glb_rdata | input | 8 | Read byte for the other global registers |
| dev_wr_stb | output | NUM_DEV | One-hot banked write strobe |
| dev_rd_stb | output | NUM_DEV | One-hot banked read strobe |
| glb_wr_stb | output | 1 | Global-space write strobe |
| glb_rd_stb | output | 1 | Global-space read strobe |
| acc_index | output | 8 | Register number of the strobed access |
| acc_wdata | output | 8 | Write byte of the strobed access |

## Verification
The assertions assume that the host never raises `io_wr` and `io_rd` in the same cycle, and that every access is a one-cycle pulse with address and data stable during it. They also assume that `dev_rdata` and `glb_rdata` depend only on the current `cfg_index` and `ldev_sel`. The bench issues each access through one task that drives one port operation per pulse with an idle cycle after it. Its stimulus is a random mix of key writes, index writes, data accesses, foreign addresses and strap changes. The read-back models are pure functions of the index and the device.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int DW = 8;

    localparam logic [DW-1:0] KEY_ENTER  = 8'h87;
    localparam logic [DW-1:0] KEY_EXIT   = 8'hAA;
    localparam logic [DW-1:0] IDX_LDEV   = 8'h07;
    localparam logic [DW-1:0] IDX_ID_HI  = 8'h20;
    localparam logic [DW-1:0] IDX_ID_LO  = 8'h21;
    localparam logic [DW-1:0] BANK_FIRST = 8'h30;
    localparam logic [DW-1:0] RD_IDLE    = 8'hFF;

    localparam logic [11:0] CHIP_FAMILY = 12'hA23;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_OPEN   = 2'd2
    } lock_state_t;

    typedef enum logic [2:0] {
        SP_LDEV   = 3'd0,
        SP_ID_HI  = 3'd1,
        SP_ID_LO  = 3'd2,
        SP_GLOBAL = 3'd3,
        SP_BANK   = 3'd4
    } reg_space_t;

    function automatic reg_space_t classify_index(input logic [DW-1:0] idx);
        reg_space_t sp;
        if (idx >= BANK_FIRST)      sp = SP_BANK;
        else if (idx == IDX_LDEV)   sp = SP_LDEV;
        else if (idx == IDX_ID_HI)  sp = SP_ID_HI;
        else if (idx == IDX_ID_LO)  sp = SP_ID_LO;
        else                        sp = SP_GLOBAL;
        return sp;
    endfunction

endpackage

// File: rtl/cfgp_port_match.sv
module cfgp_port_match #(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] BASE_LO = 'h2E,
    parameter logic [ADDR_W-1:0] BASE_HI = 'h4E
) (
    input  logic [ADDR_W-1:0] io_addr_i,
    input  logic              strap_hi_i,
    input  logic              io_wr_i,
    input  logic              io_rd_i,
    output logic              wr_idx_o,
    output logic              wr_dat_o,
    output logic              rd_idx_o,
    output logic              rd_dat_o
);

    logic [ADDR_W-1:0] base;
    logic              hit_idx;
    logic              hit_dat;

    always_comb begin
        base     = strap_hi_i ? BASE_HI : BASE_LO;
        hit_idx  = (io_addr_i == base);
        hit_dat  = (io_addr_i == base + ADDR_W'(1));
        wr_idx_o = io_wr_i && hit_idx;
        wr_dat_o = io_wr_i && hit_dat;
        rd_idx_o = io_rd_i && hit_idx;
        rd_dat_o = io_rd_i && hit_dat;
    end

endmodule

// File: rtl/cfgp_unlock_fsm.sv
module cfgp_unlock_fsm
    import cfgp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_idx_i,
    input  logic          wr_dat_i,
    input  logic          rd_idx_i,
    input  logic          rd_dat_i,
    input  logic [DW-1:0] wdata_i,
    output logic          cfg_open_o,
    output logic          idx_load_o,
    output logic          dat_wr_o,
    output logic          dat_rd_o,
    output logic          idx_rd_o
);

    lock_state_t state_q;
    lock_state_t state_d;
    logic        key_in;
    logic        key_out;

    always_comb begin
        key_in  = wr_idx_i && (wdata_i == KEY_ENTER);
        key_out = wr_idx_i && (wdata_i == KEY_EXIT);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (key_in) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (key_in)                    state_d = ST_OPEN;
                else if (wr_idx_i || wr_dat_i) state_d = ST_LOCKED;
            end
            ST_OPEN: begin
                if (key_out) state_d = ST_LOCKED;
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        cfg_open_o = (state_q == ST_OPEN);
        idx_load_o = cfg_open_o && wr_idx_i && !key_out;
        dat_wr_o   = cfg_open_o && wr_dat_i;
        dat_rd_o   = cfg_open_o && rd_dat_i;
        idx_rd_o   = cfg_open_o && rd_idx_i;
    end

    AST_SECOND_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && key_in) |=> cfg_open_o); // R2
    AST_ARM_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && wr_dat_i) |=> (state_q == ST_LOCKED)); // R3
    AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open_o && key_out) |=> !cfg_open_o); // R4
    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open_o) |-> $past(key_in)); // R2

endmodule

// File: rtl/cfgp_reg_file.sv
module cfgp_reg_file
    import cfgp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_load_i,
    input  logic          dat_wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] index_o,
    output logic [DW-1:0] ldev_o
);

    logic [DW-1:0] index_q;
    logic [DW-1:0] ldev_q;
    logic          ldev_we;

    always_comb ldev_we = dat_wr_i && (index_q == IDX_LDEV);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
            ldev_q  <= '0;
        end else begin
            if (idx_load_i) index_q <= wdata_i;
            if (ldev_we)    ldev_q  <= wdata_i;
        end
    end

    always_comb begin
        index_o = index_q;
        ldev_o  = ldev_q;
    end

    AST_LDEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_wr_i && index_q == IDX_LDEV) |=> $stable(ldev_q)); // R7
    AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_load_i |=> $stable(index_q)); // R4

endmodule

// File: rtl/cfgp_access_unit.sv
module cfgp_access_unit
    import cfgp_pkg::*;
#(
    parameter int         NUM_DEV  = 16,
    parameter logic [3:0] CHIP_REV = 4'h2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_open_i,
    input  logic                  dat_wr_i,
    input  logic                  dat_rd_i,
    input  logic                  idx_rd_i,
    input  logic                  rd_hit_i,
    input  logic [DW-1:0]         index_i,
    input  logic [DW-1:0]         ldev_i,
    input  logic [DW-1:0]         wdata_i,
    input  logic [NUM_DEV*DW-1:0] dev_rdata_i,
    input  logic [DW-1:0]         glb_rdata_i,
    output logic [NUM_DEV-1:0]    dev_wr_stb_o,
    output logic [NUM_DEV-1:0]    dev_rd_stb_o,
    output logic                  glb_wr_stb_o,
    output logic                  glb_rd_stb_o,
    output logic [DW-1:0]         acc_index_o,
    output logic [DW-1:0]         acc_wdata_o,
    output logic [DW-1:0]         rdata_o,
    output logic                  rvld_o
);

    localparam logic [2*DW-1:0] CHIP_ID = {CHIP_FAMILY, CHIP_REV};

    reg_space_t         space;
    logic [NUM_DEV-1:0] dev_hit;
    logic [DW-1:0]      bank_rdata;
    logic [DW-1:0]      reg_rdata;

    logic [NUM_DEV-1:0] dev_wr_q;
    logic [NUM_DEV-1:0] dev_rd_q;
    logic               glb_wr_q;
    logic               glb_rd_q;
    logic [DW-1:0]      acc_index_q;
    logic [DW-1:0]      acc_wdata_q;
    logic [DW-1:0]      rdata_q;
    logic               rvld_q;

    always_comb space = classify_index(index_i);

    generate
        for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev_hit
            assign dev_hit[g] = (ldev_i == DW'(g));
        end
    endgenerate

    always_comb begin
        bank_rdata = RD_IDLE;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (dev_hit[d]) bank_rdata = dev_rdata_i[d*DW +: DW];
        end
    end

    always_comb begin
        unique case (space)
            SP_LDEV:   reg_rdata = ldev_i;
            SP_ID_HI:  reg_rdata = CHIP_ID[2*DW-1:DW];
            SP_ID_LO:  reg_rdata = CHIP_ID[DW-1:0];
            SP_GLOBAL: reg_rdata = glb_rdata_i;
            SP_BANK:   reg_rdata = bank_rdata;
            default:   reg_rdata = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_wr_q    <= '0;
            dev_rd_q    <= '0;
            glb_wr_q    <= 1'b0;
            glb_rd_q    <= 1'b0;
            acc_index_q <= '0;
            acc_wdata_q <= '0;
            rdata_q     <= RD_IDLE;
            rvld_q      <= 1'b0;
        end else begin
            dev_wr_q <= (dat_wr_i && space == SP_BANK) ? dev_hit : '0;
            dev_rd_q <= (dat_rd_i && space == SP_BANK) ? dev_hit : '0;
            glb_wr_q <= dat_wr_i && (space == SP_GLOBAL);
            glb_rd_q <= dat_rd_i && (space == SP_GLOBAL);
            if (dat_wr_i || dat_rd_i) acc_index_q <= index_i;
            if (dat_wr_i)             acc_wdata_q <= wdata_i;
            rvld_q <= rd_hit_i;
            if (rd_hit_i) begin
                if (!cfg_open_i)   rdata_q <= RD_IDLE;
                else if (idx_rd_i) rdata_q <= index_i;
                else               rdata_q <= reg_rdata;
            end
        end
    end

    always_comb begin
        dev_wr_stb_o = dev_wr_q;
        dev_rd_stb_o = dev_rd_q;
        glb_wr_stb_o = glb_wr_q;
        glb_rd_stb_o = glb_rd_q;
        acc_index_o  = acc_index_q;
        acc_wdata_o  = acc_wdata_q;
        rdata_o      = rdata_q;
        rvld_o       = rvld_q;
    end

    AST_WR_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_wr_q, glb_wr_q, dev_rd_q, glb_rd_q})); // R9
    AST_WR_STB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_wr_q || glb_wr_q) |-> $past(dat_wr_i)); // R11
    AST_RD_STB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_rd_q || glb_rd_q) |-> $past(dat_rd_i)); // R11
    AST_ID_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_i && (space == SP_ID_HI || space == SP_ID_LO)) |=> !(|dev_wr_q || glb_wr_q)); // R8

endmodule

// File: rtl/cfg_port_frontend.sv
module cfg_port_frontend
    import cfgp_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter int         NUM_DEV  = 16,
    parameter logic [3:0] CHIP_REV = 4'h2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strap_hi,
    input  logic [ADDR_W-1:0]     io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [DW-1:0]         io_wdata,
    output logic [DW-1:0]         io_rdata,
    output logic                  io_rdata_vld,
    output logic                  cfg_open,
    output logic [DW-1:0]         cfg_index,
    output logic [DW-1:0]         ldev_sel,
    input  logic [NUM_DEV*DW-1:0] dev_rdata,
    input  logic [DW-1:0]         glb_rdata,
    output logic [NUM_DEV-1:0]    dev_wr_stb,
    output logic [NUM_DEV-1:0]    dev_rd_stb,
    output logic                  glb_wr_stb,
    output logic                  glb_rd_stb,
    output logic [DW-1:0]         acc_index,
    output logic [DW-1:0]         acc_wdata
);

    localparam logic [ADDR_W-1:0] BASE_LO = ADDR_W'(16'h002E);
    localparam logic [ADDR_W-1:0] BASE_HI = ADDR_W'(16'h004E);

    logic wr_idx, wr_dat, rd_idx, rd_dat;
    logic idx_load, dat_wr, dat_rd, idx_rd;

    cfgp_port_match #(
        .ADDR_W  (ADDR_W),
        .BASE_LO (BASE_LO),
        .BASE_HI (BASE_HI)
    ) u_match (
        .io_addr_i  (io_addr),
        .strap_hi_i (strap_hi),
        .io_wr_i    (io_wr),
        .io_rd_i    (io_rd),
        .wr_idx_o   (wr_idx),
        .wr_dat_o   (wr_dat),
        .rd_idx_o   (rd_idx),
        .rd_dat_o   (rd_dat)
    );

    cfgp_unlock_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_idx_i   (wr_idx),
        .wr_dat_i   (wr_dat),
        .rd_idx_i   (rd_idx),
        .rd_dat_i   (rd_dat),
        .wdata_i    (io_wdata),
        .cfg_open_o (cfg_open),
        .idx_load_o (idx_load),
        .dat_wr_o   (dat_wr),
        .dat_rd_o   (dat_rd),
        .idx_rd_o   (idx_rd)
    );

    cfgp_reg_file u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_load_i (idx_load),
        .dat_wr_i   (dat_wr),
        .wdata_i    (io_wdata),
        .index_o    (cfg_index),
        .ldev_o     (ldev_sel)
    );

    cfgp_access_unit #(
        .NUM_DEV  (NUM_DEV),
        .CHIP_REV (CHIP_REV)
    ) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_open_i   (cfg_open),
        .dat_wr_i     (dat_wr),
        .dat_rd_i     (dat_rd),
        .idx_rd_i     (idx_rd),
        .rd_hit_i     (rd_idx || rd_dat),
        .index_i      (cfg_index),
        .ldev_i       (ldev_sel),
        .wdata_i      (io_wdata),
        .dev_rdata_i  (dev_rdata),
        .glb_rdata_i  (glb_rdata),
        .dev_wr_stb_o (dev_wr_stb),
        .dev_rd_stb_o (dev_rd_stb),
        .glb_wr_stb_o (glb_wr_stb),
        .glb_rd_stb_o (glb_rd_stb),
        .acc_index_o  (acc_index),
        .acc_wdata_o  (acc_wdata),
        .rdata_o      (io_rdata),
        .rvld_o       (io_rdata_vld)
    );

    AST_LOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && wr_dat) |=> !(|dev_wr_stb || glb_wr_stb)); // R5
    AST_LOCKED_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && (rd_idx || rd_dat)) |=> (io_rdata_vld && io_rdata == RD_IDLE)); // R5
    AST_FOREIGN_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_idx || rd_dat)) |=> !io_rdata_vld); // R6

endmodule

// File: tb/cfg_port_frontend_tb.sv
module cfg_port_frontend_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_DEV    = 16;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  strap_hi = 1'b0;
    logic [15:0]           io_addr = '0;
    logic                  io_wr = 1'b0;
    logic                  io_rd = 1'b0;
    logic [7:0]            io_wdata = '0;
    logic [7:0]            io_rdata;
    logic                  io_rdata_vld;
    logic                  cfg_open;
    logic [7:0]            cfg_index;
    logic [7:0]            ldev_sel;
    logic [NUM_DEV*8-1:0]  dev_rdata;
    logic [7:0]            glb_rdata;
    logic [NUM_DEV-1:0]    dev_wr_stb;
    logic [NUM_DEV-1:0]    dev_rd_stb;
    logic                  glb_wr_stb;
    logic                  glb_rd_stb;
    logic [7:0]            acc_index;
    logic [7:0]            acc_wdata;

    int n_checks = 0;
    int n_errors = 0;

    int          m_state = 0;
    logic [7:0]  m_idx = 8'h00;
    logic [7:0]  m_ldev = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_port_frontend #(.ADDR_W(16), .NUM_DEV(NUM_DEV), .CHIP_REV(4'h2)) u_dut (
        .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_rdata_vld(io_rdata_vld), .cfg_open(cfg_open), .cfg_index(cfg_index),
        .ldev_sel(ldev_sel), .dev_rdata(dev_rdata), .glb_rdata(glb_rdata),
        .dev_wr_stb(dev_wr_stb), .dev_rd_stb(dev_rd_stb), .glb_wr_stb(glb_wr_stb),
        .glb_rd_stb(glb_rd_stb), .acc_index(acc_index), .acc_wdata(acc_wdata)
    );

    function automatic logic [7:0] dev_fn(input int d, input logic [7:0] idx);
        return 8'(d * 16 + 3) ^ idx;
    endfunction

    always_comb begin
        glb_rdata = ~cfg_index;
        for (int d = 0; d < NUM_DEV; d++) dev_rdata[d*8 +: 8] = dev_fn(d, cfg_index);
    end

    function automatic logic [7:0] read_model(input logic [7:0] idx, input logic [7:0] ld);
        if (idx == 8'h07) return ld;
        if (idx == 8'h20) return 8'hA2;
        if (idx == 8'h21) return 8'h32;
        if (idx < 8'h30)  return ~idx;
        if (ld < 8'(NUM_DEV)) return dev_fn(int'(ld), idx);
        return 8'hFF;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic acc(input logic [15:0] addr, input bit wr, input logic [7:0] d, input string tag);
        logic [15:0]        base;
        bit                 hi, hd, open, e_vld, e_gw, e_gr;
        logic [NUM_DEV-1:0] e_dw, e_dr;
        logic [7:0]         e_rd;
        base = strap_hi ? 16'h004E : 16'h002E;
        hi = (addr == base);
        hd = (addr == base + 16'd1);
        open = (m_state == 2);
        e_dw = '0; e_dr = '0; e_gw = 0; e_gr = 0;
        e_vld = !wr && (hi || hd);
        e_rd = 8'hFF;
        if (open && hd) begin
            if (m_idx >= 8'h30) begin
                if (m_ldev < 8'(NUM_DEV)) begin
                    if (wr) e_dw[int'(m_ldev)] = 1'b1; else e_dr[int'(m_ldev)] = 1'b1;
                end
            end else if (m_idx != 8'h07 && m_idx != 8'h20 && m_idx != 8'h21) begin
                if (wr) e_gw = 1; else e_gr = 1;
            end
        end
        if (e_vld && open) e_rd = hi ? m_idx : read_model(m_idx, m_ldev);
        @(negedge clk);
        io_addr = addr; io_wdata = d; io_wr = wr; io_rd = !wr;
        @(negedge clk);
        io_wr = 0; io_rd = 0;
        check(tag, "dev_wr_stb", 32'(dev_wr_stb), 32'(e_dw));
        check(tag, "dev_rd_stb", 32'(dev_rd_stb), 32'(e_dr));
        check(tag, "glb_stb", {30'd0, glb_wr_stb, glb_rd_stb}, {30'd0, e_gw, e_gr});
        check(tag, "rdata_vld", 32'(io_rdata_vld), 32'(e_vld));
        if (e_vld) check(tag, "rdata", 32'(io_rdata), 32'(e_rd));
        if ((|e_dw) || (|e_dr) || e_gw || e_gr) check(tag, "acc_index", 32'(acc_index), 32'(m_idx));
        if ((|e_dw) || e_gw) check(tag, "acc_wdata", 32'(acc_wdata), 32'(d));
        if (wr && hi) begin
            case (m_state)
                0: if (d == 8'h87) m_state = 1;
                1: m_state = (d == 8'h87) ? 2 : 0;
                default: if (d == 8'hAA) m_state = 0; else m_idx = d;
            endcase
        end else if (wr && hd) begin
            if (m_state == 1) m_state = 0;
            else if (open && m_idx == 8'h07) m_ldev = d;
        end
        check(tag, "cfg_open", 32'(cfg_open), 32'(m_state == 2));
        check(tag, "cfg_index", 32'(cfg_index), 32'(m_idx));
        check(tag, "ldev_sel", 32'(ldev_sel), 32'(m_ldev));
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        check(tag, "strobes idle", {14'd0, dev_wr_stb, glb_wr_stb, glb_rd_stb} | 32'(dev_rd_stb), 32'd0);
        check(tag, "vld idle", 32'(io_rdata_vld), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [15:0] b;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "open", 32'(cfg_open), 0);
        check("R1", "index", 32'(cfg_index), 0);
        check("R1", "ldev", 32'(ldev_sel), 0);
        idle_check("R1");
        // R5 locked accesses
        acc(16'h002F, 0, 8'h00, "R5");
        acc(16'h002E, 0, 8'h00, "R5");
        acc(16'h002F, 1, 8'h11, "R5");
        // R3 aborted unlock
        acc(16'h002E, 1, 8'h87, "R3");
        acc(16'h002F, 1, 8'h55, "R3");
        acc(16'h002E, 1, 8'h87, "R3");
        check("R3", "still locked", 32'(cfg_open), 0);
        acc(16'h002E, 1, 8'h12, "R3");
        // R2 unlock
        acc(16'h002E, 1, 8'h87, "R2");
        acc(16'h002E, 1, 8'h87, "R2");
        check("R2", "open", 32'(cfg_open), 1);
        // R8 chip id
        acc(16'h002E, 1, 8'h20, "R8");
        acc(16'h002F, 0, 8'h00, "R8");
        acc(16'h002F, 1, 8'h00, "R8");
        acc(16'h002F, 0, 8'h00, "R8");
        acc(16'h002E, 1, 8'h21, "R8");
        acc(16'h002F, 0, 8'h00, "R8");
        // R7 logical device
        acc(16'h002E, 1, 8'h07, "R7");
        acc(16'h002F, 1, 8'h05, "R7");
        acc(16'h002F, 0, 8'h00, "R7");
        // R9 banked access
        acc(16'h002E, 1, 8'h30, "R9");
        acc(16'h002F, 1, 8'h99, "R9");
        idle_check("R11");
        acc(16'h002F, 0, 8'h00, "R9");
        idle_check("R11");
        acc(16'h002E, 1, 8'h07, "R9");
        acc(16'h002F, 1, 8'h20, "R9");
        acc(16'h002E, 1, 8'hF0, "R9");
        acc(16'h002F, 1, 8'h44, "R9");
        acc(16'h002F, 0, 8'h00, "R9");
        // R10 global space
        acc(16'h002E, 1, 8'h25, "R10");
        acc(16'h002F, 1, 8'h66, "R10");
        acc(16'h002F, 0, 8'h00, "R10");
        // R6 foreign addresses and strap
        acc(16'h004E, 1, 8'hAA, "R6");
        acc(16'h004F, 0, 8'h00, "R6");
        acc(16'h0030, 1, 8'h07, "R6");
        // R4 exit keeps index
        acc(16'h002E, 1, 8'hAA, "R4");
        acc(16'h002E, 0, 8'h00, "R4");
        acc(16'h002E, 1, 8'h87, "R4");
        acc(16'h002E, 1, 8'h87, "R4");
        acc(16'h002E, 0, 8'h00, "R4");
        strap_hi = 1'b1;
        acc(16'h002E, 1, 8'hAA, "R6");
        check("R6", "old base ignored", 32'(cfg_open), 1);
        acc(16'h004E, 1, 8'hAA, "R6");
        acc(16'h004E, 1, 8'h87, "R6");
        acc(16'h004E, 1, 8'h87, "R6");
        acc(16'h004E, 1, 8'h21, "R6");
        acc(16'h004F, 0, 8'h00, "R6");
        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [7:0] v;
            if (($urandom % 60) == 0) strap_hi = ~strap_hi;
            b = strap_hi ? 16'h004E : 16'h002E;
            r = int'($urandom % 10);
            case (r)
                0, 1: acc(b, 1, 8'h87, "R2");
                2:    acc(b, 1, (($urandom % 3) == 0) ? 8'hAA : 8'h87, "R4");
                3: begin
                    case ($urandom % 4)
                        0: v = 8'h07;
                        1: v = 8'h20 + 8'($urandom % 2);
                        2: v = 8'($urandom % 48);
                        default: v = 8'h30 + 8'($urandom % 208);
                    endcase
                    if (v == 8'hAA) v = 8'hAB;
                    acc(b, 1, v, "R9");
                end
                4: acc(b + 16'd1, 1, (m_idx == 8'h07) ? 8'($urandom % 20) : 8'($urandom), "R9");
                5, 6: acc(b + 16'd1, 0, 8'h00, "R10");
                7: acc(b, 0, 8'h00, "R5");
                8: acc(16'($urandom % 128), ($urandom % 2) == 1, 8'($urandom), "R6");
                default: idle_check("R11");
            endcase
        end
        report();
    end

endmodule